// File: doc/BRIEF.md
# Sleep Interrupt Capture and Replay Controller

This block sits between a set of external interrupt lines and a parent interrupt controller. While the parent is awake and the block is disabled, each unmasked line is passed straight through to its output. Behind that path, the block watches every line all the time. It keeps a sticky per-line record of any event that matches the line's configured trigger, and it does this whether or not the block is enabled and whether or not the line is masked. Before the parent is powered down, software acknowledges stale records and enables the block. That holds every output at its inactive level while new events are captured. After wake-up, a flush command sends the captured events again toward the parent.

Software reaches the block through a simple bus. A read returns its data in the same cycle, and a write takes effect at the clock edge. Mask, trigger sensitivity and polarity each have a write-one-to-set bank and a write-one-to-clear bank. The current bits read back at the set offset. Recorded status reads back at the acknowledge offset, and writing ones there clears it. A control word holds the enable bit, the edge-only bit and a self-clearing flush bit. Replay runs in a three-state machine. S_IDLE waits for a flush write and moves to S_PULSE while taking a snapshot of the pending, unmasked lines. S_PULSE drives one cycle of active-level pulses on those lines, clears their status and always moves to S_DRAIN. S_DRAIN holds the outputs quiet for one cycle, ignores any flush write and always returns to S_IDLE.

Top module: `irq_sleep_replay`

## Requirements
- R1: Mask (set 0x0C0, clear 0x100), sensitivity (set 0x180, clear 0x1C0) and polarity (set 0x240, clear 0x280) are write-one banks. Line i is bit i mod 32 of the word at bank offset + 4*(i div 32). Zero bits change nothing, and each bank reads back its current bits at its set offset.
- R2: After reset, control reads 0, no line is masked, every line is edge-sensitive (sensitivity 0), every line has polarity 1, all status is clear, and with all inputs low every output is low.
- R3: A line with sensitivity 0 records status on a rising edge when its polarity is 1 and on a falling edge when its polarity is 0. Edges in the other direction are not recorded.
- R4: A line with sensitivity 1 and the edge-only bit (control bit 1) clear records status whenever its input is at the active level: high for polarity 1, low for polarity 0.
- R5: With the edge-only bit set, a level-sensitive line records only edges in its active direction. A steady active level is not recorded.
- R6: Status is recorded while the enable bit (control bit 0) is clear and while the line is masked. Once recorded, status stays set until it is acknowledged or replayed.
- R7: Writing a 1 to a line's bit in the acknowledge bank (offset 0x040, same word/bit mapping) clears its status, and zero bits leave status untouched. Status reads back at offset 0x040.
- R8: With enable clear, each unmasked line's output follows its input with no delay, and each masked line's output sits at its inactive level (the inverse of its polarity).
- R9: With enable set and no replay in progress, every output sits at its inactive level regardless of its input.
- R10: A control write with bit 2 (flush) set drives, in the cycle after the write edge, a one-cycle pulse at the active level on every line that has status and is unmasked. It also clears those lines' status. Masked lines keep their status and do not pulse. The flush bit reads back as 0, and the outputs return to inactive the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_in | input | N_LINES | External interrupt lines |
| irq_out | output | N_LINES | Lines toward the parent controller |

## Verification
Capture is tried with a table of line histories. Each history pairs a start level and an end level with a sensitivity, polarity and edge-only setting. Rising and falling transitions tell the two edge polarities apart. Steady high and steady low inputs separate level triggering from edge triggering and show that edge-only suppresses level capture. Replay is tried with three kinds of line at once: a rising line with polarity 1, a falling line with polarity 0, and a masked line with a record. The first two show pulses of opposite sense, and the third shows that masking blocks replay but not recording. Lines in the second register word check the word and bit mapping.

// File: rtl/sicr_pkg.sv
package sicr_pkg;

    localparam int REG_AW = 12;
    localparam int WORD_W = 32;

    localparam logic [REG_AW-1:0] OFF_ACK       = 12'h040;
    localparam logic [REG_AW-1:0] OFF_MASK_SET  = 12'h0C0;
    localparam logic [REG_AW-1:0] OFF_MASK_CLR  = 12'h100;
    localparam logic [REG_AW-1:0] OFF_SENS_SET  = 12'h180;
    localparam logic [REG_AW-1:0] OFF_SENS_CLR  = 12'h1C0;
    localparam logic [REG_AW-1:0] OFF_POL_SET   = 12'h240;
    localparam logic [REG_AW-1:0] OFF_POL_CLR   = 12'h280;
    localparam logic [REG_AW-1:0] OFF_CTRL      = 12'h300;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_EONLY_BIT = 1;
    localparam int CTRL_FLUSH_BIT = 2;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PULSE = 2'd1,
        S_DRAIN = 2'd2
    } replay_st_e;

    // True when addr selects word 'w' of the bank starting at 'base'.
    function automatic logic hit_word(input logic [REG_AW-1:0] addr,
                                      input logic [REG_AW-1:0] base,
                                      input int w);
        return (int'(addr) - int'(base)) == (w * (WORD_W / 8));
    endfunction

endpackage

// File: rtl/sicr_line_sync.sv
module sicr_line_sync #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] sense,
    input  logic         edge_only,
    output logic [N-1:0] capture
);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic s1_q, s2_q, prev_q;
        logic edge_hit, lvl_hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= irq_in[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        always_comb begin
            edge_hit = pol[i] ? (s2_q & ~prev_q) : (~s2_q & prev_q);
            lvl_hit  = (s2_q == pol[i]);
            capture[i] = (sense[i] && !edge_only) ? lvl_hit : edge_hit;
        end
    end

endmodule

// File: rtl/sicr_regbank.sv
module sicr_regbank
    import sicr_pkg::*;
#(
    parameter int N = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [N-1:0]      capture,
    input  logic [N-1:0]      replay_clr,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      sense_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      status_q,
    output logic              enable_q,
    output logic              edge_only_q,
    output logic              flush_go
);

    localparam int NW   = (N + WORD_W - 1) / WORD_W;
    localparam int NPAD = NW * WORD_W;

    logic wr, rd, ctrl_hit;
    logic [N-1:0] mset, mclr, sset, sclr, pset, pclr, ack, clr_vec;

    assign wr       = bus_en & bus_we;
    assign rd       = bus_en & ~bus_we;
    assign ctrl_hit = hit_word(bus_addr, OFF_CTRL, 0);
    assign flush_go = wr & ctrl_hit & bus_wdata[CTRL_FLUSH_BIT];

    for (genvar i = 0; i < N; i++) begin : g_dec
        localparam int WI = i / WORD_W;
        localparam int BI = i % WORD_W;
        assign mset[i] = wr & hit_word(bus_addr, OFF_MASK_SET, WI) & bus_wdata[BI];
        assign mclr[i] = wr & hit_word(bus_addr, OFF_MASK_CLR, WI) & bus_wdata[BI];
        assign sset[i] = wr & hit_word(bus_addr, OFF_SENS_SET, WI) & bus_wdata[BI];
        assign sclr[i] = wr & hit_word(bus_addr, OFF_SENS_CLR, WI) & bus_wdata[BI];
        assign pset[i] = wr & hit_word(bus_addr, OFF_POL_SET,  WI) & bus_wdata[BI];
        assign pclr[i] = wr & hit_word(bus_addr, OFF_POL_CLR,  WI) & bus_wdata[BI];
        assign ack[i]  = wr & hit_word(bus_addr, OFF_ACK,      WI) & bus_wdata[BI];
    end

    assign clr_vec = ack | replay_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q      <= '0;
            sense_q     <= '0;
            pol_q       <= '1;
            status_q    <= '0;
            enable_q    <= 1'b0;
            edge_only_q <= 1'b0;
        end else begin
            mask_q   <= (mask_q  | mset) & ~mclr;
            sense_q  <= (sense_q | sset) & ~sclr;
            pol_q    <= (pol_q   | pset) & ~pclr;
            // a new capture in the same cycle wins over a clear
            status_q <= (status_q & ~clr_vec) | capture;
            if (wr && ctrl_hit) begin
                enable_q    <= bus_wdata[CTRL_EN_BIT];
                edge_only_q <= bus_wdata[CTRL_EONLY_BIT];
            end
        end
    end

    logic [NPAD-1:0] mask_pad, sense_pad, pol_pad, status_pad;
    assign mask_pad   = NPAD'(mask_q);
    assign sense_pad  = NPAD'(sense_q);
    assign pol_pad    = NPAD'(pol_q);
    assign status_pad = NPAD'(status_q);

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (ctrl_hit) begin
                bus_rdata[CTRL_EN_BIT]    = enable_q;
                bus_rdata[CTRL_EONLY_BIT] = edge_only_q;
            end
            for (int w = 0; w < NW; w++) begin
                if (hit_word(bus_addr, OFF_MASK_SET, w)) bus_rdata = mask_pad[w*WORD_W +: WORD_W];
                if (hit_word(bus_addr, OFF_SENS_SET, w)) bus_rdata = sense_pad[w*WORD_W +: WORD_W];
                if (hit_word(bus_addr, OFF_POL_SET,  w)) bus_rdata = pol_pad[w*WORD_W +: WORD_W];
                if (hit_word(bus_addr, OFF_ACK,      w)) bus_rdata = status_pad[w*WORD_W +: WORD_W];
            end
        end
    end

    // R7: an acknowledged line with no concurrent capture is clear next cycle
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack & ~capture) != '0) |=> ((status_q & $past(ack & ~capture)) == '0));

    // R6: recorded status only drops through acknowledge or replay
    p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0));

    // R3: a detected event is present in status on the following cycle
    p_capture_recorded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture != '0) |=> (($past(capture) & ~status_q) == '0));

endmodule

// File: rtl/sicr_replay_fsm.sv
module sicr_replay_fsm
    import sicr_pkg::*;
#(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_go,
    input  logic [N-1:0] status,
    input  logic [N-1:0] mask,
    output logic [N-1:0] pulse_vec
);

    replay_st_e state_q, state_d;
    logic [N-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            pend_q <= '0;
        else if (state_q == S_IDLE && flush_go) pend_q <= status & ~mask;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (flush_go) state_d = S_PULSE;
            S_PULSE: state_d = S_DRAIN;
            S_DRAIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        pulse_vec = '0;
        unique case (state_q)
            S_PULSE: pulse_vec = pend_q;
            default: pulse_vec = '0;
        endcase
    end

    // R10: replay pulse lasts exactly one cycle, then a drain cycle
    p_pulse_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PULSE) |=> (state_q == S_DRAIN));

endmodule

// File: rtl/irq_sleep_replay.sv
module irq_sleep_replay
    import sicr_pkg::*;
#(
    parameter int N_LINES = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] irq_out
);

    logic [N_LINES-1:0] mask_q, sense_q, pol_q, status_q, capture, pulse_vec;
    logic enable_q, edge_only_q, flush_go;

    sicr_line_sync #(.N(N_LINES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .pol       (pol_q),
        .sense     (sense_q),
        .edge_only (edge_only_q),
        .capture   (capture)
    );

    sicr_regbank #(.N(N_LINES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .capture     (capture),
        .replay_clr  (pulse_vec),
        .mask_q      (mask_q),
        .sense_q     (sense_q),
        .pol_q       (pol_q),
        .status_q    (status_q),
        .enable_q    (enable_q),
        .edge_only_q (edge_only_q),
        .flush_go    (flush_go)
    );

    sicr_replay_fsm #(.N(N_LINES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_go  (flush_go),
        .status    (status_q),
        .mask      (mask_q),
        .pulse_vec (pulse_vec)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_out
        always_comb begin
            if (pulse_vec[i])      irq_out[i] = pol_q[i];
            else if (mask_q[i])    irq_out[i] = ~pol_q[i];
            else if (enable_q)     irq_out[i] = ~pol_q[i];
            else                   irq_out[i] = irq_in[i];
        end
    end

    // R10: no masked line is ever replayed
    p_masked_no_replay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulse_vec & mask_q) == '0));

endmodule

// File: tb/sim_irq_sleep_replay.sv
module sim_irq_sleep_replay;

    localparam int CLK_P = 10;
    localparam int N     = 40;

    localparam logic [11:0] A_ACK  = 12'h040;
    localparam logic [11:0] A_MSET = 12'h0C0;
    localparam logic [11:0] A_MCLR = 12'h100;
    localparam logic [11:0] A_SSET = 12'h180;
    localparam logic [11:0] A_SCLR = 12'h1C0;
    localparam logic [11:0] A_PSET = 12'h240;
    localparam logic [11:0] A_PCLR = 12'h280;
    localparam logic [11:0] A_CTRL = 12'h300;

    // {sense, pol, edge_only, start_level, end_level, expected_status}
    localparam int NV = 10;
    localparam logic [5:0] VEC [NV] = '{
        6'b0_1_0_0_1_1,  // R3 rising, pol 1
        6'b0_1_0_1_0_0,  // R3 falling ignored, pol 1
        6'b0_0_0_1_0_1,  // R3 falling, pol 0
        6'b0_0_0_0_1_0,  // R3 rising ignored, pol 0
        6'b1_1_0_0_1_1,  // R4 level high
        6'b1_1_0_0_0_0,  // R4 inactive low
        6'b1_0_0_0_0_1,  // R4 level low
        6'b1_0_0_1_1_0,  // R4 inactive high
        6'b1_1_1_1_1_0,  // R5 steady level suppressed
        6'b1_1_1_0_1_1   // R5 edge still recorded
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic [N-1:0] irq_out;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #(CLK_P/2) clk = ~clk;

    irq_sleep_replay #(.N_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R2 reset state
        rd(A_CTRL, rv);       chk("R2 ctrl", rv, 32'h0);
        rd(A_MSET, rv);       chk("R2 mask", rv, 32'h0);
        rd(A_SSET, rv);       chk("R2 sense", rv, 32'h0);
        rd(A_PSET, rv);       chk("R2 pol w0", rv, 32'hFFFF_FFFF);
        rd(A_PSET + 4, rv);   chk("R2 pol w1", rv, 32'h0000_00FF);
        rd(A_ACK, rv);        chk("R2 status", rv, 32'h0);
        chk("R2 out", {24'h0, irq_out[7:0]}, 32'h0);

        // R3 R4 R5 capture table on line 0
        for (int k = 0; k < NV; k++) begin
            logic [5:0] v;
            v = VEC[k];
            wr(v[5] ? A_SSET : A_SCLR, 32'h1);
            wr(v[4] ? A_PSET : A_PCLR, 32'h1);
            wr(A_CTRL, {30'h0, v[3], 1'b0});
            irq_in[0] = v[2];
            idle(5);
            wr(A_ACK, 32'h1);
            irq_in[0] = v[1];
            idle(5);
            rd(A_ACK, rv);
            chk($sformatf("R3/R4/R5 vector %0d", k), {31'h0, rv[0]}, {31'h0, v[0]});
        end
        wr(A_CTRL, 32'h0);
        wr(A_SCLR, 32'h1);
        wr(A_PSET, 32'h1);
        irq_in[0] = 1'b0;
        idle(5);
        wr(A_ACK, 32'hFFFF_FFFF);
        wr(A_ACK + 4, 32'hFFFF_FFFF);

        // R1 bank set/clear in word 1, line 37
        wr(A_MSET + 4, 32'h20);
        rd(A_MSET + 4, rv);   chk("R1 mask set", rv, 32'h20);
        wr(A_MCLR + 4, 32'h0);
        rd(A_MSET + 4, rv);   chk("R1 zero clear no effect", rv, 32'h20);
        wr(A_MCLR + 4, 32'h20);
        rd(A_MSET + 4, rv);   chk("R1 mask clear", rv, 32'h0);

        // R8 pass-through while disabled
        @(negedge clk);
        irq_in[2] = 1'b1;
        #1 chk("R8 passthrough", {31'h0, irq_out[2]}, 32'h1);
        wr(A_MSET, 32'h8);
        @(negedge clk);
        irq_in[3] = 1'b1;
        #1 chk("R8 masked inactive", {31'h0, irq_out[3]}, 32'h0);
        idle(5);
        // R6 recorded while masked and disabled
        rd(A_ACK, rv);        chk("R6 masked recorded", rv & 32'h8, 32'h8);

        // R9 enabled holds outputs inactive
        wr(A_CTRL, 32'h1);
        #1 chk("R9 enabled inactive", {31'h0, irq_out[2]}, 32'h0);

        // set up replay lines: 35 rising pol 1, 36 falling pol 0
        wr(A_PCLR + 4, 32'h10);
        @(negedge clk); irq_in[36] = 1'b1;
        idle(5);
        irq_in[36] = 1'b0;
        irq_in[35] = 1'b1;
        idle(5);
        rd(A_ACK + 4, rv);    chk("R3 word1 status", rv, 32'h18);
        #1 chk("R9 inactive pol0 and pol1", {30'h0, irq_out[36], irq_out[35]}, 32'h2);

        // R10 flush
        wr(A_CTRL, 32'h7);
        #1 chk("R10 pulse", {29'h0, irq_out[36], irq_out[35], irq_out[3]}, 32'h2);
        @(negedge clk);
        #1 chk("R10 pulse ends", {29'h0, irq_out[36], irq_out[35], irq_out[3]}, 32'h4);
        rd(A_ACK + 4, rv);    chk("R10 status cleared", rv, 32'h0);
        rd(A_ACK, rv);        chk("R10 masked kept", rv & 32'h8, 32'h8);
        rd(A_CTRL, rv);       chk("R10 flush reads 0", rv, 32'h3);

        // R7 acknowledge
        wr(A_ACK, 32'h0);
        rd(A_ACK, rv);        chk("R7 zero ack no effect", rv & 32'h8, 32'h8);
        wr(A_ACK, 32'h8);
        rd(A_ACK, rv);        chk("R7 ack clears", rv & 32'h8, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule